// File: doc/BRIEF.md
# Boundary-Scan Pin Cell Chain

This block is the serial test register that sits between a chip's core logic and its pads. Every bidirectional pin gets a cell with two capture/shift flops, one for the output enable and one for the data, and two update latches behind them. Every input-only pin gets a single capture/shift flop with no update stage. All cells are strung into one serial chain from `scan_in` to `scan_out`. A test access controller, not part of this block, drives the capture/shift clock enable, the shift select, the update strobe and the reset. In normal operation the pads follow the core. Under external test they follow the update latches. Several safety controls can force every driver off.

The capture stages are clocked on the rising edge of the test clock. The update latches are transparent only while the update strobe is high and the test clock is low. The serial output is retimed on the falling edge. As a result, both the latched pad values and `scan_out` change half a cycle after the rising edge that moved the chain.

Top module: `bscan_pin_chain`

## Requirements
- R1: The chain holds NUM_IN + 2*NUM_IO bits. Chain bit 0 is nearest `scan_in`, and input cell k sits at bit k. Bidirectional pin i takes bit NUM_IN+2i for its enable and bit NUM_IN+2i+1 for its data. A bit presented at `scan_in` reaches `scan_out` after exactly that many shifting rising edges.
- R2: On a rising edge with `clock_dr`=1 and `shift_dr`=0, input cell k loads `in_pin[k]`, each enable bit loads `core_oe[i]` and each data bit loads `pad_din[i]`.
- R3: On a rising edge with `clock_dr`=1 and `shift_dr`=1, every chain bit moves one place toward `scan_out`, and bit 0 takes `scan_in`.
- R4: While `clock_dr`=0, no chain bit changes, whatever `shift_dr`, `scan_in` or the pin values do.
- R5: `scan_out` shows the last chain bit, and it changes only on the falling edge of `tck` that follows the rising edge that moved the chain.
- R6: The update latches of pin i copy its enable and data chain bits while `update_dr`=1 and `tck` is low. While `update_dr`=0 they hold their value, even as the chain shifts.
- R7: With `extest`=0 and no forcing control active, `pad_oe` equals `core_oe` and `pad_dout` equals `core_dout`.
- R8: With `extest`=1, `pad_oe[i]` and `pad_dout[i]` come from pin i's enable and data update latches.
- R9: `highz`=1 or `prog_mode`=1 drives every `pad_oe` bit to 0.
- R10: `toe_n`=0 drives every `pad_oe` bit to 0.
- R11: `rst_n`=0 clears, asynchronously, every chain bit, every update latch and `scan_out`. After reset, therefore, pads under `extest`=1 are tristated and `scan_out` is 0.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| tck | input | 1 | Test clock |
| rst_n | input | 1 | Asynchronous active-low reset of chain, latches and serial output |
| clock_dr | input | 1 | Capture/shift enable for the chain flops |
| shift_dr | input | 1 | 1 selects serial shift, 0 selects parallel capture |
| update_dr | input | 1 | Opens the update latches during the low phase of `tck` |
| extest | input | 1 | Pads driven from update latches instead of the core |
| highz | input | 1 | Forces all pad drivers off |
| prog_mode | input | 1 | Device-programming mode; forces all pad drivers off |
| toe_n | input | 1 | Active-low test output enable; low forces all pad drivers off |
| scan_in | input | 1 | Serial data into chain bit 0 |
| core_dout | input | NUM_IO | Core output data per bidirectional pin |
| core_oe | input | NUM_IO | Core output enable per bidirectional pin |
| pad_din | input | NUM_IO | Value received at each bidirectional pad |
| in_pin | input | NUM_IN | Value at each input-only pin |
| pad_dout | output | NUM_IO | Data to each pad driver |
| pad_oe | output | NUM_IO | Enable of each pad driver |
| scan_out | output | 1 | Serial data out, retimed on the falling edge |

## Verification
The bench targets the chain ordering and latency. If enable and data were swapped, or input cells placed last, a captured pattern would come out in the wrong sequence. An off-by-one in the chain would move the arrival of a lone 1 away from the chain length. Retiming on the wrong clock edge would make `scan_out` change right after the rising edge, and the bench samples just there. Two further cases cover the update and hold behaviour: shifting a new pattern without an update strobe must leave the pads untouched, and a chain that moved while `clock_dr` was low would shift out corrupted data. Each forcing control is applied while the update latches hold enables of 1, so a forcing term that was dropped shows up as a driven pad. A reset that skipped the latches would leave pads driving under external test.

// File: rtl/bscan_pkg.sv
package bscan_pkg;

  // Strobes delivered by the external test access controller.
  typedef struct packed {
    logic clock_dr;   // capture/shift enable
    logic shift_dr;   // 1: serial shift, 0: parallel capture
    logic update_dr;  // update latch open (during tck low)
  } bs_strobe_t;

  function automatic int unsigned chain_bits(int unsigned n_in, int unsigned n_io);
    return n_in + 2 * n_io;
  endfunction

endpackage

// File: rtl/bs_in_cell.sv
module bs_in_cell
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  bs_strobe_t strb,
  input  logic       si,
  input  logic       pin,
  output logic       so
);

  logic cap_q;
  logic cap_d;

  always_comb begin
    cap_d = cap_q;
    if (strb.clock_dr) begin
      cap_d = strb.shift_dr ? si : pin;
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) cap_q <= 1'b0;
    else        cap_q <= cap_d;
  end

  assign so = cap_q;

  AST_IN_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    (strb.clock_dr && !strb.shift_dr) |=> (so == $past(pin)));   // R2

  AST_IN_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    !strb.clock_dr |=> $stable(so));                             // R4

endmodule

// File: rtl/bs_io_cell.sv
module bs_io_cell
  import bscan_pkg::*;
(
  input  logic       tck,
  input  logic       rst_n,
  input  bs_strobe_t strb,
  input  logic       extest,
  input  logic       force_off,
  input  logic       si,
  input  logic       core_dout,
  input  logic       core_oe,
  input  logic       pad_din,
  output logic       pad_dout,
  output logic       pad_oe,
  output logic       so
);

  // Capture/shift stage: enable bit first, data bit next toward scan-out.
  logic en_q,  en_d;
  logic dat_q, dat_d;
  // Update stage (level-sensitive).
  logic upd_en, upd_dat;
  logic upd_open;

  always_comb begin
    en_d  = en_q;
    dat_d = dat_q;
    if (strb.clock_dr) begin
      if (strb.shift_dr) begin
        en_d  = si;
        dat_d = en_q;
      end else begin
        en_d  = core_oe;
        dat_d = pad_din;
      end
    end
  end

  always_ff @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      en_q  <= 1'b0;
      dat_q <= 1'b0;
    end else begin
      en_q  <= en_d;
      dat_q <= dat_d;
    end
  end

  // Transparent only during the low phase of tck, so outputs move on the falling edge.
  assign upd_open = strb.update_dr & ~tck;

  always_latch begin
    if (!rst_n) begin
      upd_en  <= 1'b0;
      upd_dat <= 1'b0;
    end else if (upd_open) begin
      upd_en  <= en_q;
      upd_dat <= dat_q;
    end
  end

  always_comb begin
    pad_oe   = extest ? upd_en  : core_oe;
    pad_dout = extest ? upd_dat : core_dout;
    if (force_off) pad_oe = 1'b0;
  end

  assign so = dat_q;

  AST_IO_SHIFT: assert property (@(posedge tck) disable iff (!rst_n)
    (strb.clock_dr && strb.shift_dr) |=> (so == $past(en_q)));   // R3

  AST_IO_CAPTURE: assert property (@(posedge tck) disable iff (!rst_n)
    (strb.clock_dr && !strb.shift_dr) |=> (en_q == $past(core_oe) && so == $past(pad_din))); // R2

  AST_IO_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    !strb.clock_dr |=> ($stable(en_q) && $stable(so)));          // R4

  AST_UPD_HOLD: assert property (@(posedge tck) disable iff (!rst_n)
    !strb.update_dr |-> ($stable(upd_en) && $stable(upd_dat)));  // R6

endmodule

// File: rtl/bscan_pin_chain.sv
module bscan_pin_chain
  import bscan_pkg::*;
#(
  parameter int unsigned NUM_IO = 4,
  parameter int unsigned NUM_IN = 2
) (
  input  logic              tck,
  input  logic              rst_n,
  input  logic              clock_dr,
  input  logic              shift_dr,
  input  logic              update_dr,
  input  logic              extest,
  input  logic              highz,
  input  logic              prog_mode,
  input  logic              toe_n,
  input  logic              scan_in,
  input  logic [NUM_IO-1:0] core_dout,
  input  logic [NUM_IO-1:0] core_oe,
  input  logic [NUM_IO-1:0] pad_din,
  input  logic [NUM_IN-1:0] in_pin,
  output logic [NUM_IO-1:0] pad_dout,
  output logic [NUM_IO-1:0] pad_oe,
  output logic              scan_out
);

  localparam int unsigned CHAIN_LEN = chain_bits(NUM_IN, NUM_IO);

  bs_strobe_t           strb;
  logic                 force_off;
  logic [CHAIN_LEN:0]   link;
  logic                 so_d, so_q;

  assign strb.clock_dr  = clock_dr;
  assign strb.shift_dr  = shift_dr;
  assign strb.update_dr = update_dr;
  assign force_off      = highz | prog_mode | ~toe_n;
  assign link[0]        = scan_in;

  for (genvar k = 0; k < NUM_IN; k++) begin : g_in
    bs_in_cell u_cell (
      .tck   (tck),
      .rst_n (rst_n),
      .strb  (strb),
      .si    (link[k]),
      .pin   (in_pin[k]),
      .so    (link[k+1])
    );
  end

  for (genvar i = 0; i < NUM_IO; i++) begin : g_io
    bs_io_cell u_cell (
      .tck       (tck),
      .rst_n     (rst_n),
      .strb      (strb),
      .extest    (extest),
      .force_off (force_off),
      .si        (link[NUM_IN + 2*i]),
      .core_dout (core_dout[i]),
      .core_oe   (core_oe[i]),
      .pad_din   (pad_din[i]),
      .pad_dout  (pad_dout[i]),
      .pad_oe    (pad_oe[i]),
      .so        (link[NUM_IN + 2*i + 2])
    );
  end

  // Serial output retimed on the falling edge.
  always_comb so_d = link[CHAIN_LEN];

  always_ff @(negedge tck or negedge rst_n) begin
    if (!rst_n) so_q <= 1'b0;
    else        so_q <= so_d;
  end

  assign scan_out = so_q;

  AST_TOE_OFF: assert property (@(posedge tck) disable iff (!rst_n)
    !toe_n |-> (pad_oe == '0));                                  // R10

  AST_SAFE_OFF: assert property (@(posedge tck) disable iff (!rst_n)
    (highz || prog_mode) |-> (pad_oe == '0));                    // R9

  AST_SO_RISE_STABLE: assert property (@(posedge tck) disable iff (!rst_n)
    !clock_dr |=> $stable(scan_out));                            // R5

endmodule

// File: tb/bscan_pin_chain_tb.sv
module bscan_pin_chain_tb_top;

  localparam int NB = 4;
  localparam int NI = 2;
  localparam int L  = NI + 2*NB;

  logic          tck = 1'b0;
  logic          rst_n;
  logic          clock_dr, shift_dr, update_dr;
  logic          extest, highz, prog_mode, toe_n, scan_in;
  logic [NB-1:0] core_dout, core_oe, pad_din;
  logic [NI-1:0] in_pin;
  logic [NB-1:0] pad_dout, pad_oe;
  logic          scan_out;

  int    vecs   = 0;
  int    misses = 0;
  bit    done   = 0;
  string cur_req = "R11";

  always #5 tck = ~tck;   // 100 MHz

  bscan_pin_chain #(.NUM_IO(NB), .NUM_IN(NI)) dut_i (
    .tck(tck), .rst_n(rst_n), .clock_dr(clock_dr), .shift_dr(shift_dr),
    .update_dr(update_dr), .extest(extest), .highz(highz), .prog_mode(prog_mode),
    .toe_n(toe_n), .scan_in(scan_in), .core_dout(core_dout), .core_oe(core_oe),
    .pad_din(pad_din), .in_pin(in_pin), .pad_dout(pad_dout), .pad_oe(pad_oe),
    .scan_out(scan_out)
  );

  // ---------------- behavioural reference model ----------------
  bit ch[$];            // index 0 nearest scan_in
  bit so_m;
  bit l_en [NB];
  bit l_dat[NB];

  always @(posedge tck or negedge rst_n) begin
    if (!rst_n) begin
      ch = {};
      repeat (L) ch.push_back(1'b0);
    end else if (clock_dr) begin
      if (shift_dr) begin
        ch.push_front(scan_in);
        void'(ch.pop_back());
      end else begin
        for (int k = 0; k < NI; k++) ch[k] = in_pin[k];
        for (int i = 0; i < NB; i++) begin
          ch[NI+2*i]   = core_oe[i];
          ch[NI+2*i+1] = pad_din[i];
        end
      end
    end
  end

  always @(negedge tck or negedge rst_n) begin
    if (!rst_n) begin
      so_m = 1'b0;
      for (int i = 0; i < NB; i++) begin l_en[i] = 1'b0; l_dat[i] = 1'b0; end
    end else begin
      so_m = ch[L-1];
      if (update_dr) begin
        for (int i = 0; i < NB; i++) begin
          l_en[i]  = ch[NI+2*i];
          l_dat[i] = ch[NI+2*i+1];
        end
      end
    end
  end

  task automatic chk(string req, logic [31:0] act, logic [31:0] exp);
    vecs++;
    if (act !== exp) begin
      misses++;
      $display("FAIL %s actual=%0h expected=%0h at %0t", req, act, exp, $time);
    end
  endtask

  // Per-cycle comparison against the model, away from both clock edges.
  always @(negedge tck) begin
    #3;
    if (!done) begin
      logic [NB-1:0] e_oe, e_do;
      for (int i = 0; i < NB; i++) begin
        e_oe[i] = extest ? l_en[i]  : core_oe[i];
        e_do[i] = extest ? l_dat[i] : core_dout[i];
        if (highz || prog_mode || !toe_n) e_oe[i] = 1'b0;
      end
      chk(cur_req, {31'b0, scan_out}, {31'b0, so_m});
      chk(cur_req, {28'b0, pad_oe},   {28'b0, e_oe});
      chk(cur_req, {28'b0, pad_dout}, {28'b0, e_do});
    end
  end

  // ---------------- stimulus helpers ----------------
  task automatic tick(input logic c, input logic s, input logic u, input logic si);
    @(posedge tck); #1;
    clock_dr = c; shift_dr = s; update_dr = u; scan_in = si;
  endtask

  task automatic shift_in(input logic [L-1:0] p);
    for (int j = 0; j < L; j++) tick(1'b1, 1'b1, 1'b0, p[L-1-j]);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic update_pulse();
    tick(1'b0, 1'b0, 1'b1, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic shift_out_check(input logic [L-1:0] e, input string req);
    for (int j = 0; j < L; j++) begin
      tick(1'b1, 1'b1, 1'b0, 1'b0);
      @(negedge tck); #3;
      chk(req, {31'b0, scan_out}, {31'b0, e[L-1-j]});
    end
    tick(1'b0, 1'b0, 1'b0, 1'b0);
  endtask

  task automatic settle();
    @(negedge tck); #3;
  endtask

  task automatic pads_from(input logic [L-1:0] p, input string req);
    logic [NB-1:0] eo, ed;
    for (int i = 0; i < NB; i++) begin
      eo[i] = p[NI+2*i];
      ed[i] = p[NI+2*i+1];
    end
    chk(req, {28'b0, pad_oe},   {28'b0, eo});
    chk(req, {28'b0, pad_dout}, {28'b0, ed});
  endtask

  // ---------------- watchdog ----------------
  initial begin
    #1_000_000;
    if (!done) begin
      done = 1;
      misses++;
      $display("FAIL watchdog expired");
      $display("== %0d vectors applied, %0d miscompares ==", vecs, misses);
      $finish;
    end
  end

  // ---------------- test sequence ----------------
  initial begin
    logic [L-1:0] pa, pb, cv;
    int cnt;
    logic early;

    rst_n = 1'b0; clock_dr = 0; shift_dr = 0; update_dr = 0;
    extest = 1; highz = 0; prog_mode = 0; toe_n = 1; scan_in = 0;
    core_dout = '1; core_oe = '1; pad_din = '0; in_pin = '0;

    // R11: reset state
    cur_req = "R11";
    repeat (3) @(posedge tck);
    settle();
    chk("R11", {31'b0, scan_out}, 32'd0);
    chk("R11", {28'b0, pad_oe},   32'd0);
    @(posedge tck); #1 rst_n = 1'b1;
    settle();
    chk("R11", {28'b0, pad_oe},   32'd0);

    // R7: normal mode passes the core through
    cur_req = "R7";
    @(posedge tck); #1 extest = 0; core_oe = 4'b1010; core_dout = 4'b0110;
    settle();
    chk("R7", {28'b0, pad_oe},   {28'b0, 4'b1010});
    chk("R7", {28'b0, pad_dout}, {28'b0, 4'b0110});
    @(posedge tck); #1 core_oe = 4'b0101; core_dout = 4'b1001;
    settle();
    chk("R7", {28'b0, pad_oe},   {28'b0, 4'b0101});
    chk("R7", {28'b0, pad_dout}, {28'b0, 4'b1001});

    // R2 / R1: capture and order on scan-out
    cur_req = "R2";
    @(posedge tck); #1 in_pin = 2'b10; core_oe = 4'b1100; pad_din = 4'b0110;
    tick(1'b1, 1'b0, 1'b0, 1'b0);
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    for (int k = 0; k < NI; k++) cv[k] = in_pin[k];
    for (int i = 0; i < NB; i++) begin
      cv[NI+2*i]   = core_oe[i];
      cv[NI+2*i+1] = pad_din[i];
    end
    shift_out_check(cv, "R2");

    // R1 latency and R5 falling-edge timing
    cur_req = "R1";
    shift_in('0);
    tick(1'b1, 1'b1, 1'b0, 1'b1);
    cnt = 0;
    for (int n = 0; n < 3*L; n++) begin
      @(posedge tck); #1;
      scan_in = 1'b0;
      cnt++;
      early = scan_out;
      @(negedge tck); #3;
      if (scan_out === 1'b1) begin
        chk("R5", {31'b0, early}, 32'd0);
        break;
      end
    end
    tick(1'b0, 1'b0, 1'b0, 1'b0);
    chk("R1", cnt, L);

    // R8 / R3: load pattern, update, drive pads
    cur_req = "R8";
    pa = 10'b1101001110;
    core_oe = 4'b0000; core_dout = 4'b0000;
    shift_in(pa);
    update_pulse();
    @(posedge tck); #1 extest = 1;
    settle();
    pads_from(pa, "R8");
    cur_req = "R3";
    shift_out_check(pa, "R3");

    // R6: shifting without an update leaves pads alone, then update applies
    cur_req = "R6";
    pb = ~pa;
    shift_in(pb);
    settle();
    pads_from(pa, "R6");
    update_pulse();
    settle();
    pads_from(pb, "R6");

    // R4: chain frozen while clock_dr is low
    cur_req = "R4";
    for (int j = 0; j < 4; j++) tick(1'b0, 1'b1, 1'b0, j[0]);
    @(posedge tck); #1 in_pin = ~in_pin; core_oe = 4'b1111; pad_din = 4'b1001;
    for (int j = 0; j < 2; j++) tick(1'b0, 1'b0, 1'b0, 1'b1);
    shift_out_check(pb, "R4");

    // R9 / R10: forcing controls, latches hold enables of 1
    cur_req = "R9";
    shift_in(10'b1111111111);
    update_pulse();
    settle();
    chk("R9", {28'b0, pad_oe}, {28'b0, 4'b1111});
    @(posedge tck); #1 highz = 1;
    settle();
    chk("R9", {28'b0, pad_oe}, 32'd0);
    @(posedge tck); #1 highz = 0; prog_mode = 1;
    settle();
    chk("R9", {28'b0, pad_oe}, 32'd0);
    @(posedge tck); #1 extest = 0; core_oe = 4'b1111;
    settle();
    chk("R9", {28'b0, pad_oe}, 32'd0);
    cur_req = "R10";
    @(posedge tck); #1 prog_mode = 0; toe_n = 0;
    settle();
    chk("R10", {28'b0, pad_oe}, 32'd0);
    @(posedge tck); #1 extest = 1;
    settle();
    chk("R10", {28'b0, pad_oe}, 32'd0);
    @(posedge tck); #1 toe_n = 1;
    settle();
    chk("R10", {28'b0, pad_oe}, {28'b0, 4'b1111});

    // R11: reset in mid-run clears latches and serial output
    cur_req = "R11";
    @(posedge tck); #1 rst_n = 1'b0;
    settle();
    chk("R11", {28'b0, pad_oe}, 32'd0);
    chk("R11", {31'b0, scan_out}, 32'd0);
    @(posedge tck); #1 rst_n = 1'b1;
    shift_out_check('0, "R11");

    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", vecs, misses);
    $finish;
  end

endmodule